// File: doc/BRIEF.md
# Bus-Paced Response Serializer

This block sends a slave's reply to the bus master. The master drives a three-level bus waveform: idle, signal-high and signal-low. The reply is sent by switching a load-current enable while the next command frame is on the bus. The block has no local baud clock. Bit timing comes only from the level changes the master makes, so the reply goes out at the same time as the master sends its next command.

The controller arms a reply with a one-cycle strobe. With the strobe it gives a data field and a flag that chooses a short reply (8 data bits) or a long reply (16 data bits, which carry the address nibble and the status bits). The block appends a 4-bit CRC and keeps the finished word until the next frame starts. At that point the word moves into a shifter. It then leaves the shifter one bit for each falling transition of the bus, most significant bit first. If the controller does not arm a reply, for example after an errored command frame, the next frame keeps the load off. The analog current sink and its slew limiting are outside this block; the block only drives the digital enable.

Top module: `rsp_serializer`

## Requirements
- R1: After reset the load enable is low and no reply is armed, so the first frame keeps the load off for all of its bits.
- R2: A frame starts when the bus leaves idle. The first reply bit appears on `load_en` one clock after the first signal-high to signal-low change of that frame. Before that change the enable stays low. Bits go out most significant first.
- R3: Each later signal-high to signal-low change advances to the next bit. While the bus holds a non-idle level without such a change, the enable holds its value.
- R4: Whenever `bus_lvl` is idle (code 2'b00), `load_en` is low in the same cycle. A return to idle ends the frame and throws away any reply bits not yet sent.
- R5: A reply bit of 1 drives `load_en` high, and a bit of 0 drives it low.
- R6: A short reply (`rsp_long`=0) sends `rsp_data[7:0]` and then the CRC, 12 bits in all. A long reply (`rsp_long`=1) sends `rsp_data[15:0]` and then the CRC, 20 bits in all.
- R7: The CRC is a 4-bit shift register. It starts at 4'b1010 and takes the data bits most significant first. For each bit, feedback = crc[3] XOR bit; crc becomes {crc[2:0],0}; if the feedback is 1, crc is XORed with 4'b0011. The final value is sent crc[3] first.
- R8: An armed reply is sent in the next frame only, and only once. A frame that starts with nothing armed keeps the load off.
- R9: Bit times beyond the length of the reply are sent as 0 (load off).
- R10: A strobe that comes in the same cycle as a frame start does not join that frame. It is kept for the frame after.
- R11: Bus codes: 2'b00 is idle, 2'b10 is signal-low, and 2'b01 and 2'b11 are both signal-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_lvl | input | 2 | Bus level after the comparators: 00 idle, 10 low, 01/11 high |
| rsp_valid | input | 1 | One-cycle strobe that arms a reply |
| rsp_long | input | 1 | 1 for a long reply, 0 for a short reply |
| rsp_data | input | 16 | Reply data; a short reply uses bits 7:0 |
| load_en | output | 1 | Load-current enable for the bus |

## Verification
The assertions assume that `bus_lvl` has already been sampled into the clock domain and holds each level for at least one clock. They also assume the controller never strobes twice between two frame starts. The stimulus meets both: it changes the bus only on falling clock edges and holds each phase for a full cycle, and it arms at most one reply per idle gap. Random frames vary the reply length, the data and the number of extra bit times the master sends. Directed cases cover an early return to idle during a high bit, a strobe in the cycle a frame starts, and frames with nothing armed.

// File: rtl/rsp_ser_pkg.sv
package rsp_ser_pkg;
    typedef enum logic [1:0] {
        LVL_IDLE = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_LOW  = 2'b10,
        LVL_HIGH_ALT = 2'b11
    } bus_lvl_e;

    function automatic logic lvl_is_high(input logic [1:0] l);
        return (l == LVL_HIGH) || (l == LVL_HIGH_ALT);
    endfunction
endpackage

// File: rtl/rsp_lvl_edge.sv
module rsp_lvl_edge
    import rsp_ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lvl_i,
    output logic       start_o,
    output logic       fall_o,
    output logic       idle_o
);
    typedef struct packed {
        logic [1:0] lvl;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
        idle_o   = (lvl_i == LVL_IDLE);
        start_o  = (st_q.lvl == LVL_IDLE) && (lvl_i != LVL_IDLE);
        fall_o   = lvl_is_high(st_q.lvl) && (lvl_i == LVL_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: LVL_IDLE};
        else        st_q <= st_d;
    end

    // R11
    excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && fall_o));
endmodule

// File: rtl/rsp_crc.sv
module rsp_crc #(
    parameter int          LONG_DW  = 16,
    parameter int          SHORT_DW = 8,
    parameter int          CRC_W    = 4,
    parameter logic [3:0]  POLY     = 4'h3,
    parameter logic [3:0]  SEED     = 4'hA
) (
    input  logic [LONG_DW-1:0] data_i,
    input  logic               long_i,
    output logic [CRC_W-1:0]   crc_o
);
    logic [CRC_W-1:0] c;
    logic             fb;

    always_comb begin
        c  = SEED[CRC_W-1:0];
        fb = 1'b0;
        for (int i = LONG_DW - 1; i >= 0; i--) begin
            if (long_i || (i < SHORT_DW)) begin
                fb = c[CRC_W-1] ^ data_i[i];
                c  = {c[CRC_W-2:0], 1'b0};
                if (fb) c = c ^ POLY[CRC_W-1:0];
            end
        end
        crc_o = c;
    end
endmodule

// File: rtl/rsp_serializer.sv
module rsp_serializer
    import rsp_ser_pkg::*;
#(
    parameter int         LONG_DW  = 16,
    parameter int         SHORT_DW = 8,
    parameter int         CRC_W    = 4,
    parameter logic [3:0] CRC_POLY = 4'h3,
    parameter logic [3:0] CRC_SEED = 4'hA
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         bus_lvl,
    input  logic               rsp_valid,
    input  logic               rsp_long,
    input  logic [LONG_DW-1:0] rsp_data,
    output logic               load_en
);
    localparam int WORD_W  = LONG_DW + CRC_W;
    localparam int SHORT_W = SHORT_DW + CRC_W;
    localparam int PAD_W   = WORD_W - SHORT_W;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              arm_vld;
        logic [WORD_W-1:0] arm_word;
        logic [CNT_W-1:0]  arm_len;
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              drv;
    } ser_st_t;

    ser_st_t st_d, st_q;

    logic             start_w, fall_w, idle_w;
    logic [CRC_W-1:0] crc_w;
    logic [WORD_W-1:0] word_w;

    rsp_lvl_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (bus_lvl),
        .start_o(start_w),
        .fall_o (fall_w),
        .idle_o (idle_w)
    );

    rsp_crc #(
        .LONG_DW (LONG_DW),
        .SHORT_DW(SHORT_DW),
        .CRC_W   (CRC_W),
        .POLY    (CRC_POLY),
        .SEED    (CRC_SEED)
    ) u_crc (
        .data_i(rsp_data),
        .long_i(rsp_long),
        .crc_o (crc_w)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign word_w = rsp_long ? {rsp_data, crc_w}
                                     : {rsp_data[SHORT_DW-1:0], crc_w, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign word_w = {rsp_data, crc_w};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (start_w) begin
            st_d.sh      = st_q.arm_word;
            st_d.cnt     = st_q.arm_vld ? st_q.arm_len : '0;
            st_d.arm_vld = 1'b0;
            st_d.drv     = 1'b0;
        end
        if (rsp_valid) begin
            st_d.arm_vld  = 1'b1;
            st_d.arm_word = word_w;
            st_d.arm_len  = rsp_long ? CNT_W'(WORD_W) : CNT_W'(SHORT_W);
        end
        if (fall_w) begin
            if (st_q.cnt != '0) begin
                st_d.drv = st_q.sh[WORD_W-1];
                st_d.sh  = st_q.sh << 1;
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                st_d.drv = 1'b0;
            end
        end
        if (idle_w) begin
            st_d.drv = 1'b0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_en = st_q.drv && (bus_lvl != LVL_IDLE);

    // R4
    idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_w |=> !st_q.drv);
    // R3
    hold_between_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_w && !idle_w) |=> $stable(st_q.drv));
    // R9
    extra_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_w && st_q.cnt == '0) |=> !st_q.drv);
    // R8
    arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && !rsp_valid) |=> !st_q.arm_vld);
    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(st_q.cnt) <= WORD_W));
endmodule

// File: tb/sim_rsp_serializer.sv
module sim_rsp_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_lvl = 2'b00;
    logic        rsp_valid = 1'b0;
    logic        rsp_long = 1'b0;
    logic [15:0] rsp_data = '0;
    logic        load_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rsp_serializer u0 (
        .clk(clk), .rst_n(rst_n), .bus_lvl(bus_lvl), .rsp_valid(rsp_valid),
        .rsp_long(rsp_long), .rsp_data(rsp_data), .load_en(load_en)
    );

    function automatic logic [3:0] ref_crc(input logic lg, input logic [15:0] d);
        logic [3:0] c = 4'b1010;
        int n = lg ? 16 : 8;
        for (int i = n - 1; i >= 0; i--) begin
            logic f = c[3] ^ d[i];
            c = {c[2:0], 1'b0};
            if (f) c = c ^ 4'b0011;
        end
        return c;
    endfunction

    function automatic logic [19:0] ref_word(input logic lg, input logic [15:0] d);
        if (lg) return {d, ref_crc(lg, d)};
        return {d[7:0], ref_crc(lg, d), 8'h00};
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: load_en=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic arm(input logic lg, input logic [15:0] d);
        rsp_valid = 1'b1; rsp_long = lg; rsp_data = d;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    // runs one frame of nb bit times; expects word w of length len
    task automatic run_frame(input int nb, input logic [19:0] w, input int len,
                             input string tag, input bit arm_now,
                             input logic lg, input logic [15:0] d);
        bus_lvl = 2'b01;
        if (arm_now) begin
            rsp_valid = 1'b1; rsp_long = lg; rsp_data = d;
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        chk({tag, " R2 pre-bit"}, load_en, 1'b0);
        for (int k = 0; k < nb; k++) begin
            logic e = (k < len) ? w[19-k] : 1'b0;
            bus_lvl = 2'b10;
            @(negedge clk);
            chk((k < len) ? {tag, " R5 bit"} : {tag, " R9 extra"}, load_en, e);
            bus_lvl = (k % 2) ? 2'b11 : 2'b01;
            @(negedge clk);
            chk({tag, " R3 hold"}, load_en, e);
        end
        bus_lvl = 2'b00;
        #1;
        chk({tag, " R4 idle"}, load_en, 1'b0);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: load_en=%b expected=finished", load_en);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset", load_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R8: nothing armed after reset
        run_frame(12, 20'h0, 0, "R1 empty", 0, 0, 0);
        // R6 R7: short reply
        arm(1'b0, 16'h00A5);
        run_frame(12, ref_word(1'b0, 16'h00A5), 12, "R6 short", 0, 0, 0);
        // R8: sent only once
        run_frame(12, 20'h0, 0, "R8 once", 0, 0, 0);
        // R6 R7: long reply with extra bit times (R9)
        arm(1'b1, 16'hFFFF);
        run_frame(24, ref_word(1'b1, 16'hFFFF), 20, "R7 long", 0, 0, 0);
        // R10: strobe at frame start waits one frame
        arm(1'b0, 16'h003C);
        run_frame(12, ref_word(1'b0, 16'h003C), 12, "R10 first", 1, 1'b1, 16'h9E21);
        run_frame(20, ref_word(1'b1, 16'h9E21), 20, "R10 second", 0, 0, 0);
        // R4: early idle during a high bit drops the rest
        arm(1'b1, 16'hFFFF);
        bus_lvl = 2'b01; @(negedge clk);
        bus_lvl = 2'b10; @(negedge clk);
        chk("R4 abort bit", load_en, 1'b1);
        bus_lvl = 2'b00; #1;
        chk("R4 abort idle", load_en, 1'b0);
        @(negedge clk); @(negedge clk);
        run_frame(8, 20'h0, 0, "R4 after abort", 0, 0, 0);
        // random frames
        for (int it = 0; it < 30; it++) begin
            logic lg = 1'($urandom);
            logic [15:0] d = 16'($urandom);
            bit give = ($urandom % 5) != 0;
            int len = give ? (lg ? 20 : 12) : 0;
            int nb = (lg ? 20 : 12) + int'($urandom % 4);
            if (give) arm(lg, d);
            run_frame(nb, give ? ref_word(lg, d) : 20'h0, len, "R5 rand", 0, 0, 0);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule